// File: doc/BRIEF.md
# I2C Target with 16-bit Register Access

This block lets an external I2C controller read and write a bank of 16-bit registers through a plain register-file port. It oversamples SCL and SDA with a faster system clock and recognises start, repeated start and stop conditions. It answers to a 7-bit device address whose bit 5 comes from a strap input. The line is released between transfers, and during acknowledges and read data it is only ever pulled low.

A write transfer carries the device address with R/W low, then a two-byte register address and two data bytes, and both fields are sent most significant byte first. The block issues a single write strobe only once the last data byte has been acknowledged. A read first sets the register address with a write-direction header. That header is followed by a repeated start, or by a stop and then a fresh start. The controller then sends the device address with R/W high. The block pulses a read strobe as it acknowledges that header, captures the returned word, and shifts it out most significant bit first. The controller signals the end of the read with a NACK.

The block never stretches SCL and does not take part in arbitration. The register file behind it must present `reg_rdata` combinationally for the current `reg_addr` while `reg_re` is high.

Top module: `i2c_regbus_target`

## Requirements
- R1: The device address is the 7-bit value {0, addr_sel, 0, 1, 0, 1, 0} (0x0A when addr_sel is 0, 0x2A when it is 1), followed by the R/W bit (0 = write, 1 = read). When the address matches, the block pulls SDA low during the acknowledge clock.
- R2: After an address byte that does not match, the block never drives SDA and issues no strobe until the next start condition.
- R3: The two bytes that follow a write-direction header are the register address, high byte first. Each byte is acknowledged, and `reg_addr` takes the full 16-bit value only once the second byte is complete.
- R4: The next two bytes are the write data, high byte first, and each is acknowledged. One single-cycle `reg_we` pulse, with `reg_addr` and `reg_wdata` valid, follows the acknowledge of the second data byte.
- R5: A read-direction header produces a single-cycle `reg_re` pulse while its acknowledge is being driven. The word on `reg_rdata` is sampled in that cycle and returned as two bytes, high byte first, MSB first.
- R6: The block releases SDA on every ninth read clock and samples the controller's response there. A NACK ends the transfer with SDA released, and bytes read beyond the second after an ACK are 0xFF.
- R7: The register address persists across a stop, so a read that follows a stop and a new start returns the same data as one that follows a repeated start.
- R8: A start or stop before the acknowledge of the second data byte is complete abandons the transfer without any register write.
- R9: SDA is open drain: `sda_oe` high means pull low. A new low drive begins only while SCL is low. `reg_we` and `reg_re` are never high together and never stay high for two cycles.
- R10: In a write transfer, any byte after the second data byte gets no acknowledge and causes no further write.
- R11: After reset, `sda_oe`, `reg_we` and `reg_re` are low and `reg_addr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_sel | input | 1 | Strap supplying device address bit 5 |
| scl_i | input | 1 | Serial clock line as seen on the pin |
| sda_i | input | 1 | Serial data line as seen on the pin |
| sda_oe | output | 1 | Pull SDA low when high, release when low |
| reg_addr | output | 16 | Register address to the register file |
| reg_wdata | output | 16 | Write data to the register file |
| reg_we | output | 1 | Single-cycle register write strobe |
| reg_re | output | 1 | Single-cycle register read strobe |
| reg_rdata | input | 16 | Read data, valid while reg_re is high |

## Verification
The assertions are checked on every cycle. They cover the strobe shapes and their mutual exclusion, and that a low drive starts only while SCL is low. They also check that a write strobe coincides with the release of the final data acknowledge, and that a read strobe coincides with the start of the header acknowledge. Only the bench's scenarios can show protocol-level results. These are address matching for both strap values, silence after a mismatch, and the MSB-first order of the address, data and read bytes. They also cover the effect of aborted and over-long writes and the behaviour of reads that follow a stop.

// File: rtl/i2c_tgt_pkg.sv
// Package: shared types for the I2C register target.
// Assumes nothing beyond IEEE 1800-2017 enums.
package i2c_tgt_pkg;

    // Protocol phase of the target engine
    typedef enum logic [2:0] {
        PH_IDLE,     // waiting for a start, SDA released
        PH_HDR,      // shifting in the device address byte
        PH_HDR_ACK,  // driving ACK for a matched header
        PH_RXB,      // shifting in a register address or data byte
        PH_RXB_ACK,  // driving ACK for a received byte
        PH_TXB,      // shifting out a read byte
        PH_TXB_ACK   // SDA released, sampling controller ACK/NACK
    } tgt_phase_e;

endpackage

// File: rtl/i2c_line_sync.sv
// Module: i2c_line_sync
// Brings SCL and SDA into the system clock domain through a
// STAGES-deep flop chain and derives SCL edges plus start and
// stop conditions from the synchronized levels.
// Assumes the system clock samples each SCL phase several times.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_chain;
    logic [STAGES-1:0] sda_chain;
    logic              scl_prev;
    logic              sda_prev;
    logic              scl_s;

    // Synchronizer chains, idle-high after reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_chain <= '1;
            sda_chain <= '1;
        end else begin
            scl_chain <= {scl_chain[STAGES-2:0], scl_i};
            sda_chain <= {sda_chain[STAGES-2:0], sda_i};
        end
    end

    assign scl_s = scl_chain[STAGES-1];
    assign sda_s = sda_chain[STAGES-1];

    // One-cycle history of the synchronized levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_s;
            sda_prev <= sda_s;
        end
    end

    // Edge and bus-condition decode
    always_comb begin
        scl_rise  = scl_s & ~scl_prev;
        scl_fall  = ~scl_s & scl_prev;
        start_det = scl_s & scl_prev & sda_prev & ~sda_s;
        stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;
    end

endmodule

// File: rtl/i2c_tgt_engine.sv
// Module: i2c_tgt_engine
// Byte-level protocol engine of the I2C register target: header
// match, ACK generation, register address and data assembly, read
// shifting and register strobes. Works on the synchronized events
// from i2c_line_sync. Assumes AW and DW are multiples of 8 and at
// least 16, and that reg_rdata is valid while reg_re is high.
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sda_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic [6:0]    dev_addr,
    output logic          sda_oe,
    output logic [AW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    output logic          reg_we,
    output logic          reg_re,
    input  logic [DW-1:0] reg_rdata
);

    localparam int ABYTES = AW / 8;
    localparam int DBYTES = DW / 8;
    localparam int NBYTES = ABYTES + DBYTES;
    localparam int IDXW   = $clog2(NBYTES + 1);
    localparam logic [IDXW-1:0] IDX_ALAST = IDXW'(ABYTES - 1);
    localparam logic [IDXW-1:0] IDX_LAST  = IDXW'(NBYTES - 1);
    localparam logic [IDXW-1:0] IDX_END   = IDXW'(NBYTES);

    tgt_phase_e      phase;
    logic [3:0]      bit_cnt;
    logic [7:0]      rx_sh;
    logic [IDXW-1:0] byte_idx;
    logic [AW-1:0]   addr_hold;
    logic [DW-1:0]   tx_sh;
    logic            ctl_nack;
    logic            byte_done;

    // A full byte has been clocked in and SCL has just fallen
    assign byte_done = scl_fall && (bit_cnt == 4'd8);

    // Protocol sequencer with data-path registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            bit_cnt   <= '0;
            rx_sh     <= '0;
            byte_idx  <= '0;
            addr_hold <= '0;
            tx_sh     <= '1;
            ctl_nack  <= 1'b0;
            sda_oe    <= 1'b0;
            reg_addr  <= '0;
            reg_wdata <= '0;
            reg_we    <= 1'b0;
            reg_re    <= 1'b0;
        end else begin
            reg_we <= 1'b0;
            reg_re <= 1'b0;
            if (reg_re) begin
                tx_sh <= reg_rdata;
            end
            if (start_det) begin
                phase    <= PH_HDR;
                bit_cnt  <= '0;
                byte_idx <= '0;
                sda_oe   <= 1'b0;
            end else if (stop_det) begin
                phase  <= PH_IDLE;
                sda_oe <= 1'b0;
            end else begin
                unique case (phase)
                    PH_IDLE: ;
                    PH_HDR: begin
                        if (scl_rise) begin
                            rx_sh   <= {rx_sh[6:0], sda_s};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (byte_done) begin
                            if (rx_sh[7:1] == dev_addr) begin
                                phase  <= PH_HDR_ACK;
                                sda_oe <= 1'b1;
                                reg_re <= rx_sh[0];
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end
                    end
                    PH_HDR_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (rx_sh[0]) begin
                                phase  <= PH_TXB;
                                sda_oe <= ~tx_sh[DW-1];
                            end else begin
                                phase  <= PH_RXB;
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    PH_RXB: begin
                        if (scl_rise) begin
                            rx_sh   <= {rx_sh[6:0], sda_s};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (byte_done) begin
                            if (byte_idx == IDX_END) begin
                                phase <= PH_IDLE;
                            end else begin
                                phase  <= PH_RXB_ACK;
                                sda_oe <= 1'b1;
                                if (byte_idx < IDX_ALAST) begin
                                    addr_hold <= {addr_hold[AW-9:0], rx_sh};
                                end else if (byte_idx == IDX_ALAST) begin
                                    reg_addr <= {addr_hold[AW-9:0], rx_sh};
                                end else begin
                                    reg_wdata <= {reg_wdata[DW-9:0], rx_sh};
                                end
                            end
                        end
                    end
                    PH_RXB_ACK: begin
                        if (scl_fall) begin
                            phase    <= PH_RXB;
                            sda_oe   <= 1'b0;
                            bit_cnt  <= '0;
                            byte_idx <= byte_idx + 1'b1;
                            reg_we   <= (byte_idx == IDX_LAST);
                        end
                    end
                    PH_TXB: begin
                        if (scl_fall) begin
                            tx_sh <= {tx_sh[DW-2:0], 1'b1};
                            if (bit_cnt == 4'd7) begin
                                phase   <= PH_TXB_ACK;
                                sda_oe  <= 1'b0;
                                bit_cnt <= '0;
                            end else begin
                                sda_oe  <= ~tx_sh[DW-2];
                                bit_cnt <= bit_cnt + 4'd1;
                            end
                        end
                    end
                    PH_TXB_ACK: begin
                        if (scl_rise) begin
                            ctl_nack <= sda_s;
                        end else if (scl_fall) begin
                            if (ctl_nack) begin
                                phase <= PH_IDLE;
                            end else begin
                                phase  <= PH_TXB;
                                sda_oe <= ~tx_sh[DW-1];
                            end
                        end
                    end
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_regbus_target.sv
// Module: i2c_regbus_target (top)
// I2C target giving an external controller 16-bit-addressed access
// to a 16-bit register file. Composes the line synchronizer and the
// protocol engine and forms the device address from the strap.
// Assumes clk runs at least ~10x faster than SCL; SDA is open drain.
module i2c_regbus_target #(
    parameter int         AW          = 16,
    parameter int         DW          = 16,
    parameter int         SYNC_STAGES = 2,
    parameter logic [4:0] DEV_ID_LOW  = 5'b01010,
    parameter logic       DEV_ID_TOP  = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_sel,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe,
    output logic [AW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    output logic          reg_we,
    output logic          reg_re,
    input  logic [DW-1:0] reg_rdata
);

    logic       sda_s;
    logic       scl_rise;
    logic       scl_fall;
    logic       start_det;
    logic       stop_det;
    logic [6:0] dev_addr;

    // Device address with the strap in bit 5
    assign dev_addr = {DEV_ID_TOP, addr_sel, DEV_ID_LOW};

    i2c_line_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    i2c_tgt_engine #(
        .AW(AW),
        .DW(DW)
    ) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det),
        .dev_addr (dev_addr),
        .sda_oe   (sda_oe),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_we   (reg_we),
        .reg_re   (reg_re),
        .reg_rdata(reg_rdata)
    );

endmodule

// File: rtl/i2c_regbus_target_chk.sv
// Module: i2c_regbus_target_chk
// Protocol checker bound to i2c_regbus_target; observes ports only.
module i2c_regbus_target_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_i,
    input logic          sda_oe,
    input logic          reg_we,
    input logic          reg_re,
    input logic [AW-1:0] reg_addr
);

    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);                                   // R9
    AST_RE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |=> !reg_re);                                   // R9
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_re));                                  // R9
    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i);                             // R9
    AST_WE_AT_ACK_END: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (!sda_oe && $past(sda_oe)));                // R4
    AST_WE_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> $stable(reg_addr));                         // R3
    AST_RE_AT_HDR_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |-> (sda_oe && !$past(sda_oe)));                // R5

endmodule

bind i2c_regbus_target i2c_regbus_target_chk #(.AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (scl_i),
    .sda_oe  (sda_oe),
    .reg_we  (reg_we),
    .reg_re  (reg_re),
    .reg_addr(reg_addr)
);

// File: tb/tb_i2c_regbus_target.sv
// Directed bench for i2c_regbus_target: a bit-banged I2C controller,
// a small register-file model and one task per scenario.
module tb_i2c_regbus_target;

    localparam int Q = 10;  // quarter SCL period in clk cycles

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_sel = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_line;
    logic        sda_oe;
    logic [15:0] reg_addr;
    logic [15:0] reg_wdata;
    logic        reg_we;
    logic        reg_re;
    logic [15:0] reg_rdata;

    logic [15:0] mem [16];
    int          we_cnt = 0;
    int          re_cnt = 0;
    int          oe_cyc = 0;
    logic [15:0] last_waddr = '0;
    logic [15:0] last_wdata = '0;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    assign sda_line  = sda_m & ~sda_oe;
    assign reg_rdata = mem[reg_addr[3:0]];

    i2c_regbus_target dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_sel (addr_sel),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .sda_oe   (sda_oe),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_we   (reg_we),
        .reg_re   (reg_re),
        .reg_rdata(reg_rdata)
    );

    // Register-file model and strobe monitor
    always @(posedge clk) begin
        if (reg_we) begin
            mem[reg_addr[3:0]] <= reg_wdata;
            we_cnt     <= we_cnt + 1;
            last_waddr <= reg_addr;
            last_wdata <= reg_wdata;
        end
        if (reg_re) re_cnt <= re_cnt + 1;
        if (sda_oe) oe_cyc <= oe_cyc + 1;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2 * Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1; tick(2 * Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        acked = !sda_line;
        tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit give_ack);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl_m = 1'b1; tick(Q);
            b[i] = sda_line;
            tick(Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = !give_ack; tick(Q);
        scl_m = 1'b1; tick(2 * Q);
        scl_m = 1'b0; tick(Q);
        sda_m = 1'b1;
    endtask

    // Full write: header, address, data; returns count of missing ACKs
    task automatic do_write(input logic [6:0] dev, input logic [15:0] a,
                            input logic [15:0] d, output int nacks);
        bit ak;
        nacks = 0;
        bus_start();
        send_byte({dev, 1'b0}, ak); if (!ak) nacks++;
        send_byte(a[15:8], ak);     if (!ak) nacks++;
        send_byte(a[7:0], ak);      if (!ak) nacks++;
        send_byte(d[15:8], ak);     if (!ak) nacks++;
        send_byte(d[7:0], ak);      if (!ak) nacks++;
        bus_stop();
        tick(Q);
    endtask

    task automatic do_read(input logic [15:0] a, input bit via_stop,
                           output logic [15:0] d);
        bit ak;
        logic [7:0] hi, lo;
        bus_start();
        send_byte(8'h14, ak);
        send_byte(a[15:8], ak);
        send_byte(a[7:0], ak);
        if (via_stop) bus_stop();
        bus_start();
        send_byte(8'h15, ak);
        recv_byte(hi, 1'b1);
        recv_byte(lo, 1'b0);
        bus_stop();
        tick(Q);
        d = {hi, lo};
    endtask

    task automatic t_reset();
        chk(sda_oe == 1'b0, "R11", "sda_oe after reset", sda_oe, 0);
        chk(reg_we == 1'b0, "R11", "reg_we after reset", reg_we, 0);
        chk(reg_re == 1'b0, "R11", "reg_re after reset", reg_re, 0);
        chk(reg_addr == 16'h0, "R11", "reg_addr after reset", reg_addr, 0);
    endtask

    task automatic t_write_basic();
        int n, w0;
        w0 = we_cnt;
        do_write(7'h0A, 16'hA503, 16'hBEEF, n);
        chk(n == 0, "R1", "missing ACKs on write", n, 0);
        chk(we_cnt == w0 + 1, "R4", "write strobes", we_cnt - w0, 1);
        chk(last_waddr == 16'hA503, "R3", "register address", last_waddr, 16'hA503);
        chk(last_wdata == 16'hBEEF, "R4", "write data", last_wdata, 16'hBEEF);
        do_write(7'h0A, 16'h0007, 16'h1234, n);
        chk(last_wdata == 16'h1234 && n == 0, "R4", "second write data",
            last_wdata, 16'h1234);
    endtask

    task automatic t_read_restart();
        int r0;
        logic [15:0] d;
        r0 = re_cnt;
        do_read(16'hA503, 1'b0, d);
        chk(d == 16'hBEEF, "R5", "read via repeated start", d, 16'hBEEF);
        chk(re_cnt == r0 + 1, "R5", "read strobes", re_cnt - r0, 1);
    endtask

    task automatic t_read_stop();
        logic [15:0] d;
        do_read(16'h0007, 1'b1, d);
        chk(d == 16'h1234, "R7", "read via stop then start", d, 16'h1234);
    endtask

    task automatic t_mismatch();
        int w0, o0;
        bit ak;
        w0 = we_cnt; o0 = oe_cyc;
        bus_start();
        send_byte(8'h54, ak);
        chk(!ak, "R2", "ACK on foreign address", ak, 0);
        send_byte(8'h00, ak);
        send_byte(8'h03, ak);
        send_byte(8'h55, ak);
        send_byte(8'h66, ak);
        bus_stop();
        tick(Q);
        chk(oe_cyc == o0, "R2", "SDA drive cycles after mismatch", oe_cyc - o0, 0);
        chk(we_cnt == w0, "R2", "writes after mismatch", we_cnt - w0, 0);
    endtask

    task automatic t_strap();
        int n, w0;
        bit ak;
        addr_sel = 1'b1;
        tick(Q);
        w0 = we_cnt;
        do_write(7'h2A, 16'h0009, 16'h5A5A, n);
        chk(n == 0 && we_cnt == w0 + 1, "R1", "write at strap address 0x2A",
            n, 0);
        bus_start();
        send_byte(8'h14, ak);
        bus_stop();
        chk(!ak, "R1", "ACK of 0x0A with strap high", ak, 0);
        addr_sel = 1'b0;
        tick(Q);
    endtask

    task automatic t_abort();
        int w0;
        bit ak;
        logic [15:0] d;
        w0 = we_cnt;
        bus_start();
        send_byte(8'h14, ak);
        send_byte(8'h00, ak);
        send_byte(8'h07, ak);
        send_byte(8'hDE, ak);
        bus_stop();
        tick(Q);
        chk(we_cnt == w0, "R8", "write after stop mid-data", we_cnt - w0, 0);
        bus_start();
        send_byte(8'h14, ak);
        send_byte(8'h00, ak);
        send_byte(8'h07, ak);
        send_byte(8'hDE, ak);
        bus_start();
        send_byte(8'h16, ak);
        bus_stop();
        tick(Q);
        chk(we_cnt == w0, "R8", "write after restart mid-data", we_cnt - w0, 0);
        do_read(16'h0007, 1'b0, d);
        chk(d == 16'h1234, "R8", "register after aborts", d, 16'h1234);
    endtask

    task automatic t_extra();
        int w0;
        bit ak;
        w0 = we_cnt;
        bus_start();
        send_byte(8'h14, ak);
        send_byte(8'h00, ak);
        send_byte(8'h0C, ak);
        send_byte(8'hC0, ak);
        send_byte(8'hDE, ak);
        send_byte(8'h77, ak);
        chk(!ak, "R10", "ACK of fifth write byte", ak, 0);
        bus_stop();
        tick(Q);
        chk(we_cnt == w0 + 1, "R10", "writes with extra byte", we_cnt - w0, 1);
        chk(last_wdata == 16'hC0DE, "R10", "data with extra byte", last_wdata, 16'hC0DE);
    endtask

    task automatic t_read_long();
        bit ak;
        logic [7:0] b0, b1, b2;
        bus_start();
        send_byte(8'h14, ak);
        send_byte(8'h00, ak);
        send_byte(8'h0C, ak);
        bus_start();
        send_byte(8'h15, ak);
        recv_byte(b0, 1'b1);
        recv_byte(b1, 1'b1);
        recv_byte(b2, 1'b0);
        chk({b0, b1} == 16'hC0DE, "R6", "first two read bytes", {b0, b1}, 16'hC0DE);
        chk(b2 == 8'hFF, "R6", "third read byte", b2, 8'hFF);
        tick(Q);
        chk(sda_oe == 1'b0, "R6", "SDA after NACK", sda_oe, 0);
        bus_stop();
        tick(Q);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 16'h0000;
        tick(5);
        rst_n = 1'b1;
        tick(5);
        t_reset();
        t_write_basic();
        t_read_restart();
        t_read_stop();
        t_mismatch();
        t_strap();
        t_abort();
        t_extra();
        t_read_long();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule